// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It takes the line through a two-flop synchronizer and runs in one of two timing modes. In oversampled mode a one-cycle enable arrives sixteen times per bit period. A falling edge starts a phase count, and the start bit is confirmed partway through its period before data is accepted. In direct mode the far end supplies a bit-rate clock, and every rising edge of that clock takes one sample with no start confirmation.

Each finished character appears on a parallel output with parity-error, framing-error and break flags, marked by a one-cycle load strobe. Character length (five to eight data bits) and parity (none, even or odd) come from static configuration inputs. Two line conditions get special handling. A long low level yields a single zero character and a break-change pulse at each end of the break. A character that fails its stop check can be followed at once by a new character that has no falling edge of its own. Buffering, baud generation and host access sit outside the block.

Top module: `uartRx`

## Requirements
- R1: After reset, charData is zero, the three error flags are low, and neither charValid nor breakChange pulses until a character or break is seen.
- R2: In oversampled mode (mode16 = 1) a falling edge must still be low at the seventh tickEn after the edge tick. If the line is high there, the receiver discards the attempt, hunts for a new falling edge and loads nothing.
- R3: In oversampled mode each data bit is sampled at the midpoint of its sixteen-tick period, least significant bit first. The character is presented on charData together with a charValid pulse that lasts exactly one clock. charData changes only in that cycle.
- R4: dataBits selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Positions above the length read as zero.
- R5: parityCfg[0] enables a parity bit after the data, and parityCfg[1] selects odd (1) or even (0). parityErr is set when the ones count over data plus parity bit does not match the selected sense. parityErr is always low with parity disabled.
- R6: A stop bit sampled low sets frameErr on the loaded character. frameErr is clear when the stop sample is high.
- R7: In oversampled mode, if a character with a nonzero data or parity bit fails its stop check and the line is still low eight ticks after the stop sample, that point is taken as a new start edge. The next character is received with no intervening falling edge.
- R8: A line held low through data, parity and stop loads exactly one character with charData = 0, breakFlag = 1, frameErr = 1 and parityErr = 0. It also issues one single-clock breakChange pulse. No further character is loaded while the line stays low.
- R9: A break ends only after the synchronized line is high on two consecutive clock edges. The end produces a second breakChange pulse, and hunting for a start resumes. A high level lasting one clock does not end the break.
- R10: In direct mode (mode16 = 0) the line is sampled on each rising edge of bitClk. Any low sample while hunting is accepted as a start bit without confirmation, and the next samples are taken as data, parity and stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode16 | input | 1 | 1 = sixteen-times oversampling on tickEn, 0 = direct sampling on bitClk |
| tickEn | input | 1 | One-cycle oversampling enable, sixteen per bit period |
| bitClk | input | 1 | Bit-rate clock for direct mode, sampled in the clk domain |
| rxLine | input | 1 | Serial input line, idle high |
| dataBits | input | 2 | Character length code, 0..3 for 5..8 bits |
| parityCfg | input | 2 | Bit 0 parity enable, bit 1 odd select |
| charData | output | 8 | Received character, upper unused bits zero |
| parityErr | output | 1 | Parity mismatch on the loaded character |
| frameErr | output | 1 | Stop bit sampled low on the loaded character |
| breakFlag | output | 1 | Loaded character is a break |
| charValid | output | 1 | One-clock load strobe |
| breakChange | output | 1 | One-clock pulse at break entry and at break exit |

## Verification
The assertions assume that dataBits and parityCfg stay fixed for the whole time a character is in flight. They also assume that tickEn pulses are spaced widely enough for a line change to clear the synchronizer before the next tick. The stimulus changes configuration and mode only while the line has been idle high for at least two bit periods. It fires tickEn once every four clocks and moves rxLine one clock after a tick edge, so every level is stable before it is sampled. In direct mode bitClk has a period of eight clocks, and the line changes on the low phase, four clocks before each rise.

// File: rtl/uartRxPkg.sv
package uartRxPkg;
  localparam int MAX_BITS = 8;
  localparam int IDX_W = $clog2(MAX_BITS);

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_FRAMEWAIT,
    ST_BREAK
  } rxState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic             clear;
    logic             capData;
    logic             capParity;
    logic             loadChar;
    logic             loadBreak;
    logic             pulseChange;
    logic [IDX_W-1:0] bitIdx;
  } rxStrobe_t;
endpackage

// File: rtl/uartRxSync.sv
module uartRxSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxLine,
  input  logic bitClk,
  output logic lineS,
  output logic bitRise
);
  logic [STAGES-1:0] lineSh;
  logic [STAGES:0]   clkSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineSh <= '1;
      clkSh  <= '0;
    end else begin
      lineSh <= {lineSh[STAGES-2:0], rxLine};
      clkSh  <= {clkSh[STAGES-1:0], bitClk};
    end
  end

  assign lineS   = lineSh[STAGES-1];
  assign bitRise = clkSh[STAGES-1] & ~clkSh[STAGES];
endmodule

// File: rtl/uartRxCtrl.sv
module uartRxCtrl
  import uartRxPkg::*;
#(
  parameter int OVS        = 16,
  parameter int BREAK_HIGH = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      mode16,
  input  logic      tickEn,
  input  logic      bitRise,
  input  logic      lineS,
  input  logic [1:0] dataBits,
  input  logic      parEn,
  input  logic      allZero,
  output rxStrobe_t strb
);
  localparam int PW  = $clog2(OVS);
  localparam int HCW = $clog2(BREAK_HIGH + 1);
  localparam logic [PW-1:0]  MID_PH     = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0]  RESTART_PH = PW'(OVS - 1);
  localparam logic [HCW-1:0] HIGH_LAST  = HCW'(BREAK_HIGH - 1);

  rxState_t         state, stateN;
  logic [PW-1:0]    phase, phaseN, phaseInc;
  logic [IDX_W-1:0] bitCnt, bitCntN, lastIdx;
  logic [HCW-1:0]   highCnt, highCntN;
  logic             prevS, prevN;
  logic             step, atMid;

  assign step     = mode16 ? tickEn : bitRise;
  assign phaseInc = phase + 1'b1;
  assign atMid    = mode16 ? (phaseInc == MID_PH) : 1'b1;
  assign lastIdx  = IDX_W'(dataBits) + IDX_W'(4);

  always_comb begin
    stateN   = state;
    phaseN   = phase;
    bitCntN  = bitCnt;
    highCntN = highCnt;
    prevN    = prevS;
    strb     = '0;
    strb.bitIdx = bitCnt;
    case (state)
      ST_HUNT: begin
        if (step) begin
          if (mode16) begin
            prevN = lineS;
            if (prevS && !lineS) begin
              phaseN    = '0;
              stateN    = ST_START;
              strb.clear = 1'b1;
            end
          end else if (!lineS) begin
            bitCntN    = '0;
            stateN     = ST_DATA;
            strb.clear = 1'b1;
          end
        end
      end
      ST_START: begin
        if (step) begin
          phaseN = phaseInc;
          if (atMid) begin
            if (!lineS) begin
              bitCntN = '0;
              stateN  = ST_DATA;
            end else begin
              prevN  = 1'b1;
              stateN = ST_HUNT;
            end
          end
        end
      end
      ST_DATA: begin
        if (step) begin
          phaseN = phaseInc;
          if (atMid) begin
            strb.capData = 1'b1;
            if (bitCnt == lastIdx) stateN = parEn ? ST_PARITY : ST_STOP;
            else bitCntN = bitCnt + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (step) begin
          phaseN = phaseInc;
          if (atMid) begin
            strb.capParity = 1'b1;
            stateN = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        if (step) begin
          phaseN = phaseInc;
          if (atMid) begin
            if (!lineS && allZero) begin
              strb.loadBreak   = 1'b1;
              strb.pulseChange = 1'b1;
              highCntN = '0;
              stateN   = ST_BREAK;
            end else begin
              strb.loadChar = 1'b1;
              if (!lineS && mode16) begin
                stateN = ST_FRAMEWAIT;
              end else begin
                prevN  = lineS;
                stateN = ST_HUNT;
              end
            end
          end
        end
      end
      ST_FRAMEWAIT: begin
        if (step) begin
          phaseN = phaseInc;
          if (phaseInc == RESTART_PH) begin
            if (!lineS) begin
              phaseN     = '0;
              strb.clear = 1'b1;
              stateN     = ST_START;
            end else begin
              prevN  = 1'b1;
              stateN = ST_HUNT;
            end
          end
        end
      end
      ST_BREAK: begin
        if (lineS) begin
          if (highCnt == HIGH_LAST) begin
            strb.pulseChange = 1'b1;
            highCntN = '0;
            prevN    = 1'b1;
            stateN   = ST_HUNT;
          end else begin
            highCntN = highCnt + 1'b1;
          end
        end else begin
          highCntN = '0;
        end
      end
      default: stateN = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      phase   <= '0;
      bitCnt  <= '0;
      highCnt <= '0;
      prevS   <= 1'b1;
    end else begin
      state   <= stateN;
      phase   <= phaseN;
      bitCnt  <= bitCntN;
      highCnt <= highCntN;
      prevS   <= prevN;
    end
  end
endmodule

// File: rtl/uartRxData.sv
module uartRxData
  import uartRxPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineS,
  input  rxStrobe_t           strb,
  input  logic                parEn,
  input  logic                parOdd,
  output logic [MAX_BITS-1:0] charData,
  output logic                parityErr,
  output logic                frameErr,
  output logic                breakFlag,
  output logic                charValid,
  output logic                breakChange,
  output logic                allZero
);
  logic [MAX_BITS-1:0] shiftReg, capEn;
  logic                parReg;

  for (genvar i = 0; i < MAX_BITS; i++) begin : gCap
    assign capEn[i] = strb.capData && (strb.bitIdx == IDX_W'(i));
  end

  assign allZero = (shiftReg == '0) && !(parEn && parReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      parReg      <= 1'b0;
      charData    <= '0;
      parityErr   <= 1'b0;
      frameErr    <= 1'b0;
      breakFlag   <= 1'b0;
      charValid   <= 1'b0;
      breakChange <= 1'b0;
    end else begin
      charValid   <= 1'b0;
      breakChange <= strb.pulseChange;
      if (strb.clear) begin
        shiftReg <= '0;
        parReg   <= 1'b0;
      end else begin
        for (int b = 0; b < MAX_BITS; b++) begin
          if (capEn[b]) shiftReg[b] <= lineS;
        end
        if (strb.capParity) parReg <= lineS;
      end
      if (strb.loadChar) begin
        charData  <= shiftReg;
        parityErr <= parEn && ((^shiftReg ^ parReg) != parOdd);
        frameErr  <= ~lineS;
        breakFlag <= 1'b0;
        charValid <= 1'b1;
      end else if (strb.loadBreak) begin
        charData  <= '0;
        parityErr <= 1'b0;
        frameErr  <= 1'b1;
        breakFlag <= 1'b1;
        charValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uartRx.sv
module uartRx
  import uartRxPkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BREAK_HIGH  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mode16,
  input  logic       tickEn,
  input  logic       bitClk,
  input  logic       rxLine,
  input  logic [1:0] dataBits,
  input  logic [1:0] parityCfg,
  output logic [7:0] charData,
  output logic       parityErr,
  output logic       frameErr,
  output logic       breakFlag,
  output logic       charValid,
  output logic       breakChange
);
  logic      lineS, bitRise, allZero;
  rxStrobe_t strb;

  uartRxSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .bitClk(bitClk),
    .lineS(lineS), .bitRise(bitRise)
  );

  uartRxCtrl #(.OVS(OVS), .BREAK_HIGH(BREAK_HIGH)) uCtrl (
    .clk(clk), .rstN(rstN), .mode16(mode16), .tickEn(tickEn),
    .bitRise(bitRise), .lineS(lineS), .dataBits(dataBits),
    .parEn(parityCfg[0]), .allZero(allZero), .strb(strb)
  );

  uartRxData uData (
    .clk(clk), .rstN(rstN), .lineS(lineS), .strb(strb),
    .parEn(parityCfg[0]), .parOdd(parityCfg[1]),
    .charData(charData), .parityErr(parityErr), .frameErr(frameErr),
    .breakFlag(breakFlag), .charValid(charValid),
    .breakChange(breakChange), .allZero(allZero)
  );
endmodule

// File: rtl/uartRxChecker.sv
module uartRxChecker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] dataBits,
  input logic       parEn,
  input logic [7:0] charData,
  input logic       parityErr,
  input logic       frameErr,
  input logic       breakFlag,
  input logic       charValid,
  input logic       breakChange
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> !charValid); // R3
  AST_DATA_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(charData) |-> charValid); // R3
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    charValid |-> ((charData >> (4'(dataBits) + 4'd5)) == 8'd0)); // R4
  AST_NO_PARITY_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !parEn) |-> !parityErr); // R5
  AST_BREAK_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && breakFlag) |-> (charData == 8'd0 && frameErr && !parityErr)); // R8
  AST_CHANGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    breakChange |=> !breakChange); // R9
endmodule

bind uartRx uartRxChecker uChk (
  .clk(clk), .rstN(rstN), .dataBits(dataBits), .parEn(parityCfg[0]),
  .charData(charData), .parityErr(parityErr), .frameErr(frameErr),
  .breakFlag(breakFlag), .charValid(charValid), .breakChange(breakChange)
);

// File: tb/uartRx_test.sv
module uartRx_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mode16 = 1'b1;
  logic       tickEn;
  logic       bitClk = 1'b0;
  logic       rxLine = 1'b1;
  logic [1:0] dataBits = 2'd3;
  logic [1:0] parityCfg = 2'd0;
  logic [7:0] charData;
  logic       parityErr, frameErr, breakFlag, charValid, breakChange;

  int nChecks = 0;
  int nFails  = 0;
  int loads   = 0;
  int changes = 0;
  int tickDiv;
  logic [7:0] lastData;
  logic lastPe, lastFe, lastBrk;
  bit   done = 1'b0;

  // fields: lenCode[2] parityCfg[2] badPar[1] data[8] expData[8] expPe[1]
  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {2'd3, 2'b00, 1'b0, 8'hA5, 8'hA5, 1'b0},
    {2'd0, 2'b00, 1'b0, 8'hFF, 8'h1F, 1'b0},
    {2'd1, 2'b01, 1'b0, 8'h3C, 8'h3C, 1'b0},
    {2'd2, 2'b11, 1'b0, 8'h55, 8'h55, 1'b0},
    {2'd3, 2'b01, 1'b1, 8'h81, 8'h81, 1'b1},
    {2'd3, 2'b11, 1'b1, 8'h00, 8'h00, 1'b1},
    {2'd2, 2'b00, 1'b0, 8'h80, 8'h00, 1'b0},
    {2'd0, 2'b11, 1'b0, 8'h0A, 8'h0A, 1'b0}
  };

  uartRx uut (
    .clk(clk), .rstN(rstN), .mode16(mode16), .tickEn(tickEn), .bitClk(bitClk),
    .rxLine(rxLine), .dataBits(dataBits), .parityCfg(parityCfg),
    .charData(charData), .parityErr(parityErr), .frameErr(frameErr),
    .breakFlag(breakFlag), .charValid(charValid), .breakChange(breakChange)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      tickDiv <= 0;
      tickEn  <= 1'b0;
    end else begin
      tickDiv <= (tickDiv == 3) ? 0 : tickDiv + 1;
      tickEn  <= (tickDiv == 3);
    end
  end

  always @(negedge clk) begin
    if (charValid) begin
      loads    <= loads + 1;
      lastData <= charData;
      lastPe   <= parityErr;
      lastFe   <= frameErr;
      lastBrk  <= breakFlag;
    end
    if (breakChange) changes <= changes + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!tickEn);
    end
    #1;
  endtask

  task automatic bit16(input logic v, input int n);
    rxLine = v;
    waitTicks(n);
  endtask

  task automatic send16(input logic [7:0] d, input int len, input logic pEn,
                        input logic pOdd, input logic bad, input logic stopV,
                        input int stopTicks);
    logic p;
    p = pOdd ^ bad;
    bit16(1'b0, 16);
    for (int i = 0; i < len; i++) begin
      bit16(d[i], 16);
      p = p ^ d[i];
    end
    if (pEn) bit16(p, 16);
    bit16(stopV, stopTicks);
  endtask

  task automatic bit1x(input logic v);
    rxLine = v;
    bitClk = 1'b0;
    repeat (4) @(posedge clk);
    #1 bitClk = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int l0, c0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 charData", charData, 0);
    check("R1 flags", {parityErr, frameErr, breakFlag}, 0);
    check("R1 strobes", loads + changes, 0);
    waitTicks(1);
    bit16(1'b1, 32);

    // R2 short low pulse rejected
    l0 = loads;
    bit16(1'b0, 4);
    bit16(1'b1, 40);
    check("R2 glitch ignored", loads, l0);

    // table of characters: R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      dataBits  = VEC[v][21:20];
      parityCfg = VEC[v][19:18];
      l0 = loads;
      send16(VEC[v][16:9], int'(VEC[v][21:20]) + 5, VEC[v][18], VEC[v][19],
             VEC[v][17], 1'b1, 16);
      bit16(1'b1, 32);
      check("R3 load count", loads, l0 + 1);
      check("R3 R4 data", lastData, VEC[v][8:1]);
      check("R5 parity flag", lastPe, VEC[v][0]);
      check("R6 no frame error", {lastFe, lastBrk}, 0);
    end

    // R6 framing error, line back high before restart point
    dataBits = 2'd3;
    parityCfg = 2'b00;
    l0 = loads;
    send16(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 10);
    bit16(1'b1, 40);
    check("R6 one load", loads, l0 + 1);
    check("R6 data", lastData, 8'h5A);
    check("R6 frameErr", {lastFe, lastBrk}, 2'b10);

    // R7 restart with no falling edge after framing error
    l0 = loads;
    send16(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b0, 16);
    send16(8'h33, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16);
    bit16(1'b1, 40);
    check("R7 two loads", loads, l0 + 2);
    check("R7 second data", lastData, 8'h33);
    check("R7 second clean", {lastFe, lastBrk}, 0);

    // R8 break
    l0 = loads;
    c0 = changes;
    bit16(1'b0, 400);
    check("R8 single load", loads, l0 + 1);
    check("R8 zero char", lastData, 0);
    check("R8 flags", {lastBrk, lastFe, lastPe}, 3'b110);
    check("R8 change pulse", changes, c0 + 1);

    // R9 one-clock high does not end break
    @(negedge clk);
    rxLine = 1'b1;
    @(negedge clk);
    rxLine = 1'b0;
    waitTicks(20);
    check("R9 short high ignored", changes, c0 + 1);
    check("R9 no load on short high", loads, l0 + 1);
    bit16(1'b1, 20);
    check("R9 end pulse", changes, c0 + 2);
    l0 = loads;
    send16(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b1, 16);
    bit16(1'b1, 32);
    check("R9 hunting resumed", loads, l0 + 1);
    check("R9 data after break", {lastData, lastBrk, lastFe}, {8'h96, 2'b00});

    // R10 direct mode
    mode16 = 1'b0;
    repeat (3) bit1x(1'b1);
    l0 = loads;
    bit1x(1'b0);
    for (int i = 0; i < 8; i++) bit1x(8'hC3 >> i);
    bit1x(1'b1);
    repeat (3) bit1x(1'b1);
    check("R10 load", loads, l0 + 1);
    check("R10 data", {lastData, lastFe}, {8'hC3, 1'b0});
    l0 = loads;
    bit1x(1'b0);
    repeat (12) bit1x(1'b1);
    check("R10 no start confirmation", loads, l0 + 1);
    check("R10 all ones", {lastData, lastFe}, {8'hFF, 1'b0});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule